// File: doc/BRIEF.md
# Intra-Field Line-Doubling Deinterlacer

This block turns interlaced 24-bit RGB video into progressive video. Every field that arrives becomes one output frame with twice as many lines. Pixels enter over a valid/ready handshake, together with a line-start flag, a field-start flag and a field-parity bit. A single line memory holds the most recent input line.

For each input line of a kept field the block sends out two lines. The first is a vertical interpolation. It is produced while the input line is accepted, and each pixel is the per-channel rounded average of the incoming pixel and the pixel at the same position in the previous line. The second line is a replay of the input line itself. It is read back from the line memory, and the input is stalled while it plays.

A parameter halves the output frame rate by consuming one field parity without producing any output. A second parameter selects which parity counts as even. The line length and the lines per field are sampled once after reset.

Top module: `fieldline_doubler`

## Requirements
- R1: A beat is taken only on a rising edge with `in_val` and `in_rdy` both high. After the last pixel of a kept line is accepted, `in_rdy` is low for exactly one line length of cycles (the replay), and is high otherwise.
- R2: After reset, beats are consumed and produce no output until the first accepted beat with `in_vs` high.
- R3: Each kept input line produces two output lines in this order: the interpolated line, then the input line repeated unchanged. A field of N lines produces exactly 2N output lines. Beats that follow the N-th line and come before the next field start are consumed without output.
- R4: Interpolated pixels are computed per 8-bit channel (bits 23:16, 15:8, 7:0) as (a+b+1)>>1, where a is the previous line's pixel in the same column and b is the current pixel. No channel overflows.
- R5: On the first line of a field, the interpolated line equals the current line.
- R6: `out_hs` is high on the first pixel of every output line. `out_vs` is high only on the first pixel of a frame, and both are valid only when `out_val` is high.
- R7: With `HALF_RATE`=1, fields whose parity bit differs from `EVEN_FLAG` are consumed with `in_rdy` held high and produce no output.
- R8: `px_per_line` and `lines_per_fld` are sampled once after reset. Later changes have no effect until the next reset.
- R9: During and right after reset, `out_val` is low and `in_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| px_per_line | input | 12 | Pixels per input line |
| lines_per_fld | input | 12 | Lines per input field |
| in_pix | input | 24 | Input RGB pixel |
| in_hs | input | 1 | First pixel of an input line |
| in_vs | input | 1 | First pixel of an input field |
| in_fld | input | 1 | Field parity, sampled with `in_vs` |
| in_val | input | 1 | Input beat valid |
| in_rdy | output | 1 | Block accepts a beat |
| out_pix | output | 24 | Output RGB pixel |
| out_hs | output | 1 | First pixel of an output line |
| out_vs | output | 1 | First pixel of an output frame |
| out_val | output | 1 | Output pixel valid |

## Verification
The hardest state to reach from the ports is a change of the format inputs between resets while fields keep flowing. The stimulus changes the line length in the middle of a run and keeps sending fields of the old length; any use of the new value would shift line ends and the replay length. Rounding at the channel limits can only be reached through chosen data, so a directed field pairs full-scale, zero and odd-neighbour channels between lines. Random pixel data and idle gaps fill the remaining fields, and the bench also sends dropped-parity fields and stray beats after the end of a field.

// File: rtl/fdbl_pkg.sv
package fdbl_pkg;
  localparam int CH_W  = 8;
  localparam int N_CH  = 3;
  localparam int PIX_W = CH_W * N_CH;
  localparam int CFG_W = 12;

  typedef enum logic [1:0] {ST_WAIT, ST_RUN, ST_REPLAY} fdbl_st_e;

  // Rounded mean of two channel values; the 9-bit sum cannot overflow.
  function automatic logic [CH_W-1:0] ch_mean(input logic [CH_W-1:0] a,
                                              input logic [CH_W-1:0] b);
    logic [CH_W:0] s;
    s = {1'b0, a} + {1'b0, b} + {{CH_W{1'b0}}, 1'b1};
    return s[CH_W:1];
  endfunction
endpackage

// File: rtl/fdbl_linestore.sv
module fdbl_linestore #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  // Read returns the old word when raddr == waddr in a write cycle.
  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/fdbl_blend.sv
module fdbl_blend
  import fdbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] upper,
  input  logic [PIX_W-1:0] lower,
  output logic [PIX_W-1:0] mixed
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    wire [CH_W-1:0] ua = upper[c*CH_W +: CH_W];
    wire [CH_W-1:0] lb = lower[c*CH_W +: CH_W];
    wire [CH_W-1:0] mc = ch_mean(ua, lb);
    assign mixed[c*CH_W +: CH_W] = mc;

    AST_MEAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((mc >= ua) || (mc >= lb)) && ((mc <= ua) || (mc <= lb))); // R4
  end
endmodule

// File: rtl/fieldline_doubler.sv
module fieldline_doubler
  import fdbl_pkg::*;
#(
  parameter int LS_LOG2   = 10,
  parameter bit HALF_RATE = 1'b0,
  parameter bit EVEN_FLAG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      px_per_line,
  input  logic [11:0]      lines_per_fld,
  input  logic [23:0]      in_pix,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic             in_fld,
  input  logic             in_val,
  output logic             in_rdy,
  output logic [23:0]      out_pix,
  output logic             out_hs,
  output logic             out_vs,
  output logic             out_val
);
  localparam int AW = LS_LOG2;

  fdbl_st_e          st;
  logic [CFG_W-1:0]  cfg_ppl, cfg_lpf;
  logic              cfg_ld;
  logic [AW-1:0]     wx, rx;
  logic [CFG_W-1:0]  ly;
  logic              keep_q, seen_vs;

  // Named events for the assertions and the datapath.
  wire             beat      = in_val && in_rdy;
  wire             vs_beat   = beat && in_vs;
  wire             live      = vs_beat || (beat && st == ST_RUN);
  wire [AW-1:0]    waddr     = (in_hs || in_vs) ? '0 : wx;
  wire             keep_new  = !HALF_RATE || (in_fld == EVEN_FLAG);
  wire             keep_now  = vs_beat ? keep_new : keep_q;
  wire             first_ln  = vs_beat || (ly == '0);
  wire [CFG_W-1:0] cur_ly    = vs_beat ? '0 : ly;
  wire             line_end  = live && (CFG_W'(waddr) == cfg_ppl - 1'b1);
  wire             last_ln   = (cur_ly == cfg_lpf - 1'b1);
  wire             rep_end   = (st == ST_REPLAY) && (CFG_W'(rx) == cfg_ppl - 1'b1);

  wire [PIX_W-1:0] ls_rd;
  wire [PIX_W-1:0] mixed;
  wire [PIX_W-1:0] interp = first_ln ? in_pix : mixed;

  assign in_rdy = (st != ST_REPLAY);

  fdbl_linestore #(.ADDR_W(AW), .DATA_W(PIX_W)) u_ls (
    .clk   (clk),
    .we    (live),
    .waddr (waddr),
    .wdata (in_pix),
    .raddr ((st == ST_REPLAY) ? rx : waddr),
    .rdata (ls_rd)
  );

  fdbl_blend u_blend (
    .clk   (clk),
    .rst_n (rst_n),
    .upper (ls_rd),
    .lower (in_pix),
    .mixed (mixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_WAIT;
      cfg_ppl <= '0;
      cfg_lpf <= '0;
      cfg_ld  <= 1'b0;
      wx      <= '0;
      rx      <= '0;
      ly      <= '0;
      keep_q  <= 1'b0;
      seen_vs <= 1'b0;
      out_pix <= '0;
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
      out_val <= 1'b0;
    end else begin
      if (!cfg_ld) begin
        cfg_ppl <= px_per_line;
        cfg_lpf <= lines_per_fld;
        cfg_ld  <= 1'b1;
      end
      out_val <= 1'b0;
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
      if (live) begin
        wx <= waddr + 1'b1;
        if (vs_beat) begin
          seen_vs <= 1'b1;
          keep_q  <= keep_new;
          ly      <= '0;
        end
        if (keep_now) begin
          out_val <= 1'b1;
          out_pix <= interp;
          out_hs  <= (waddr == '0);
          out_vs  <= vs_beat;
        end
        st <= ST_RUN;
        if (line_end) begin
          wx <= '0;
          if (keep_now) begin
            st <= ST_REPLAY;
            rx <= '0;
          end else if (last_ln) begin
            st <= ST_WAIT;
          end else begin
            ly <= cur_ly + 1'b1;
          end
        end
      end else if (st == ST_REPLAY) begin
        out_val <= 1'b1;
        out_pix <= ls_rd;
        out_hs  <= (rx == '0);
        rx      <= rx + 1'b1;
        if (rep_end) begin
          if (ly == cfg_lpf - 1'b1) st <= ST_WAIT;
          else begin
            st <= ST_RUN;
            ly <= ly + 1'b1;
          end
        end
      end
    end
  end

  AST_SILENT_BEFORE_VS: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_vs && !vs_beat) |=> !out_val); // R2
  AST_STALL_STARTS_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rdy) |=> (out_val && out_hs)); // R1
  AST_VS_MARKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vs |-> (out_hs && out_val)); // R6
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !in_vs && !keep_q) |=> !out_val); // R7
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ld |=> ($stable(cfg_ppl) && $stable(cfg_lpf))); // R8
endmodule

// File: tb/fieldline_doubler_tb.sv
module fieldline_doubler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] px_per_line = 12'd6;
  logic [11:0] lines_per_fld = 12'd3;
  logic [23:0] in_pix = '0;
  logic        in_hs = 1'b0, in_vs = 1'b0, in_fld = 1'b0, in_val = 1'b0;
  wire         in_rdy, out_hs, out_vs, out_val;
  wire  [23:0] out_pix;

  int checks = 0;
  int failures = 0;
  int out_seen = 0;

  logic [23:0] exp_pix[$];
  bit          exp_hs[$];
  bit          exp_vs[$];
  string       exp_tag[$];

  always #10 clk = ~clk;

  fieldline_doubler #(.LS_LOG2(10), .HALF_RATE(1'b1), .EVEN_FLAG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .px_per_line(px_per_line), .lines_per_fld(lines_per_fld),
    .in_pix(in_pix), .in_hs(in_hs), .in_vs(in_vs), .in_fld(in_fld), .in_val(in_val),
    .in_rdy(in_rdy), .out_pix(out_pix), .out_hs(out_hs), .out_vs(out_vs), .out_val(out_val)
  );

  function automatic logic [23:0] ref_mean(input logic [23:0] a, input logic [23:0] b);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) begin
      int sa = (a >> (8 * c)) & 255;
      int sb = (b >> (8 * c)) & 255;
      int m  = (sa + sb + 1) / 2;
      r[8*c +: 8] = m[7:0];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic push_exp(input logic [23:0] p, input bit hs, input bit vs, input string tag);
    exp_pix.push_back(p); exp_hs.push_back(hs); exp_vs.push_back(vs); exp_tag.push_back(tag);
  endtask

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && out_val) begin
      out_seen++;
      if (exp_pix.size() == 0) begin
        check(1'b0, "R2/R3/R7", "unexpected output", {8'h0, out_pix}, 32'h0);
      end else begin
        logic [23:0] ep; bit eh, ev; string tg;
        ep = exp_pix.pop_front(); eh = exp_hs.pop_front();
        ev = exp_vs.pop_front(); tg = exp_tag.pop_front();
        check(out_pix == ep, tg, "pixel", {8'h0, out_pix}, {8'h0, ep});
        check(out_hs == eh && out_vs == ev, "R6", "hs/vs",
              {30'h0, out_hs, out_vs}, {30'h0, eh, ev});
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_val = 1'b0; in_hs = 1'b0; in_vs = 1'b0;
    end
  endtask

  task automatic send_beat(input logic [23:0] p, input bit hs, input bit vs,
                           input bit fld, output int stalls);
    @(negedge clk);
    in_pix = p; in_hs = hs; in_vs = vs; in_fld = fld; in_val = 1'b1;
    stalls = 0;
    while (!in_rdy) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  // mode 0: random pixels, mode 1: directed rounding corners
  task automatic run_field(input int ppl, input int lpf, input bit fld,
                           input bit keep, input int mode);
    logic [23:0] prev [64];
    logic [23:0] cur  [64];
    int st;
    for (int k = 0; k < lpf; k++) begin
      for (int x = 0; x < ppl; x++) begin
        if (mode == 1) cur[x] = (k % 2 == 0) ? 24'hFF00FE : 24'h0001FF;
        else           cur[x] = 24'($urandom);
        if (keep) begin
          if (k == 0) push_exp(cur[x], x == 0, x == 0, "R5");
          else        push_exp(ref_mean(prev[x], cur[x]), x == 0, 1'b0, "R4");
        end
        if (x != 0 && mode == 0 && ($urandom % 4) == 0) idle(1 + $urandom % 2);
        send_beat(cur[x], x == 0, (k == 0 && x == 0), fld, st);
        if (x == 0 && k > 0) begin
          if (keep) check(st == ppl, "R1", "replay stall length", st, ppl);
          else      check(st == 0, "R7", "dropped field stall", st, 0);
        end
      end
      if (keep)
        for (int x = 0; x < ppl; x++) push_exp(cur[x], x == 0, 1'b0, "R3");
      for (int x = 0; x < ppl; x++) prev[x] = cur[x];
    end
    idle(ppl + 4);
  endtask

  task automatic do_reset(input logic [11:0] ppl, input logic [11:0] lpf);
    @(negedge clk);
    rst_n = 1'b0; in_val = 1'b0;
    px_per_line = ppl; lines_per_fld = lpf;
    exp_pix.delete(); exp_hs.delete(); exp_vs.delete(); exp_tag.delete();
    idle(3);
    check(out_val == 1'b0, "R9", "out_val in reset", out_val, 0);
    check(in_rdy == 1'b1, "R9", "in_rdy in reset", in_rdy, 1);
    rst_n = 1'b1;
    idle(2);
    check(out_val == 1'b0 && in_rdy == 1'b1, "R9", "state after reset",
          {30'h0, out_val, in_rdy}, 32'h1);
  endtask

  task automatic expect_drained(input string req);
    check(exp_pix.size() == 0, req, "outputs missing", exp_pix.size(), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int st, seen0;
    void'($urandom(32'h5EED_0107));
    do_reset(12'd6, 12'd3);

    // R2: beats before the first field start give nothing
    seen0 = out_seen;
    for (int i = 0; i < 5; i++) send_beat(24'($urandom), i == 0, 1'b0, 1'b1, st);
    idle(6);
    check(out_seen == seen0, "R2", "output before vsync", out_seen, seen0);

    // R3/R4/R5: kept field, random data
    run_field(6, 3, 1'b1, 1'b1, 0);
    expect_drained("R3");

    // R3: stray beats after field end are ignored
    seen0 = out_seen;
    for (int i = 0; i < 4; i++) send_beat(24'($urandom), i == 0, 1'b0, 1'b1, st);
    idle(6);
    check(out_seen == seen0, "R3", "output after field end", out_seen, seen0);

    // R7: odd field dropped
    seen0 = out_seen;
    run_field(6, 3, 1'b0, 1'b0, 0);
    check(out_seen == seen0, "R7", "dropped field output", out_seen, seen0);

    // R8: format change without reset has no effect
    px_per_line = 12'd4; lines_per_fld = 12'd2;
    run_field(6, 3, 1'b1, 1'b1, 0);
    expect_drained("R8");
    run_field(6, 3, 1'b1, 1'b1, 0);
    expect_drained("R8");

    // R8 after reset: new format, directed rounding corners for R4
    do_reset(12'd4, 12'd2);
    run_field(4, 2, 1'b1, 1'b1, 1);
    expect_drained("R8");
    check(out_seen > 0, "R4", "directed outputs seen", out_seen, 1);

    // mixed random fields
    for (int f = 0; f < 4; f++) begin
      bit fb = 1'($urandom);
      run_field(4, 2, fb, fb, 0);
      expect_drained("R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule